// File: doc/BRIEF.md
# Multiplexed MDIO Management Master

This block is a management-bus master for a chip that hosts several separate MDIO segments. Some segments sit inside the chip and some leave it through pads. A host programs a small word-addressed register file. The parameter register carries the target segment, the PHY address, the framing mode and the write data. The address register carries the register number, or the device and register address for extended framing. A write to the control word then launches a single read or write. One shared transaction engine divides the system clock down to MDC and serialises the frame. During reads it captures the PHY's reply. Its clock and data are steered only to the chosen segment.

Each access uses either the basic frame (start 01) or the extended two-frame sequence (an address frame, then an operation frame with start 00). Completion raises a sticky done flag. The host must clear done by writing zero to the control word before it can launch another access. Control writes that arrive while an access runs are dropped. The steering and frame fields are frozen when the access starts, so the host may reprogram the registers for the next access while the current one is still on the wire.

Top module: `mdio_mux_master`

## Requirements
- R1: After reset, every segment has MDC low, output enable low and data output low. The status word reads 0, and the parameter and address registers read 0.
- R2: The registers use byte offsets on reg_addr. The parameter register at 0x00 is read/write over all 32 bits. Read data at 0x04 is read-only and returns the captured value in bits [15:0] with zeros above. The address register at 0x08 is read/write. The control word at 0x0C reads as 0. Status at 0x10 returns done in bit 0. Any other offset reads 0.
- R3: A control write of 0x1 starts a write and 0x2 starts a read, provided the engine is idle and done is clear. Any other nonzero value starts nothing. A control write of 0 while idle clears done.
- R4: A control write is ignored while an access is in progress. A start request is ignored while done is still set.
- R5: Every frame bit lasts 2*MDC_HALF clocks: MDC is low for MDC_HALF clocks, then high for MDC_HALF clocks. The first bit begins, with MDC low, in the cycle after the accepted control write. Output data changes only when MDC falls, and input data is sampled as MDC rises.
- R6: With parameter bit 21 clear, the engine sends 32 ones and then one frame, MSB first. The frame is start 01, opcode 01 (write) or 10 (read), the PHY address from parameter bits [20:16], the register from address bits [4:0], turnaround 10, and the 16 data bits from parameter bits [15:0].
- R7: With parameter bit 21 set, the engine sends two frames, each preceded by 32 ones. The first frame is start 00, opcode 00, PHY, device address bits [20:16], turnaround 10, and address bits [15:0]. The second frame uses the same device field with opcode 01 (write) or 11 (read) and 16 data bits.
- R8: In the frame that carries read data, output enable is low for the two turnaround bits and the 16 data bits. The 16 bits sampled there are returned at offset 0x04, first bit in bit 15. A write access leaves the read data unchanged.
- R9: Parameter bit 25 = 1 selects internal segment number param[24:22], and bit 25 = 0 selects external segment number param[24:22]. Every other segment keeps MDC low, output enable low and output low. A number beyond the implemented count drives no segment, still completes, and reads as 0xFFFF.
- R10: Steering and frame fields are captured when the access starts. Register writes during the access do not change it.
- R11: Done rises exactly once per access. It rises in the clock after the last bit's high half, 2*MDC_HALF*(64 or 128) clocks after the accepted control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| int_mdc | output | N_INT | MDC for each internal segment |
| int_mdio_o | output | N_INT | Data output for each internal segment |
| int_mdio_oe | output | N_INT | Output enable for each internal segment |
| int_mdio_i | input | N_INT | Data input from each internal segment |
| ext_mdc | output | N_EXT | MDC for each external segment |
| ext_mdio_o | output | N_EXT | Data output for each external segment |
| ext_mdio_oe | output | N_EXT | Output enable for each external segment |
| ext_mdio_i | input | N_EXT | Data input from each external segment |

## Verification
The bench builds the block with MDC_HALF = 2, N_INT = 3 and N_EXT = 2. The short MDC half-period keeps a full extended access to 512 clocks, so every pin of every bit can be compared against the reference model cycle by cycle. Because fewer segments are implemented than the 3-bit number field can name, an unimplemented internal number is reachable and checked. Both internal and external steering are exercised.

// File: rtl/mdio_mux_pkg.sv
package mdio_mux_pkg;

   // register byte offsets
   localparam logic [4:0] OFS_PARAM = 5'h00;
   localparam logic [4:0] OFS_RDATA = 5'h04;
   localparam logic [4:0] OFS_ADDR  = 5'h08;
   localparam logic [4:0] OFS_CTRL  = 5'h0C;
   localparam logic [4:0] OFS_STAT  = 5'h10;

   // parameter register field positions
   localparam int P_PHY_LSB = 16;
   localparam int P_EXTFRM  = 21;
   localparam int P_BUS_LSB = 22;
   localparam int P_INTSEL  = 25;

   localparam logic [31:0] CMD_WRITE = 32'h1;
   localparam logic [31:0] CMD_READ  = 32'h2;

   typedef struct packed {
      logic        ext_frame;
      logic        is_read;
      logic        internal;
      logic [2:0]  seg;
      logic [4:0]  phy;
      logic [31:0] raddr;
      logic [15:0] wdata;
   } xfer_t;

   function automatic logic [31:0] mk_frame(input logic [1:0] st, input logic [1:0] op,
                                            input logic [4:0] phy, input logic [4:0] dev,
                                            input logic [15:0] body);
      return {st, op, phy, dev, 2'b10, body};
   endfunction

endpackage

// File: rtl/mdio_mux_regs.sv
module mdio_mux_regs
   import mdio_mux_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [4:0]  addr,
   input  logic [31:0] wdata,
   input  logic        busy,
   input  logic        done_set,
   input  logic [15:0] cap_data,
   output logic [31:0] rdata,
   output logic        start,
   output xfer_t       xfer
);

   logic [31:0] param_q;
   logic [31:0] raddr_q;
   logic        done_q;
   logic        ctrl_wr;

   assign ctrl_wr = we && (addr == OFS_CTRL);
   assign start   = ctrl_wr && !busy && !done_q &&
                    ((wdata == CMD_WRITE) || (wdata == CMD_READ));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         param_q <= '0;
         raddr_q <= '0;
         done_q  <= 1'b0;
      end else begin
         if (we && addr == OFS_PARAM) param_q <= wdata;
         if (we && addr == OFS_ADDR)  raddr_q <= wdata;
         if (done_set)
            done_q <= 1'b1;
         else if (ctrl_wr && !busy && wdata == '0)
            done_q <= 1'b0;
      end
   end

   always_comb begin
      xfer.ext_frame = param_q[P_EXTFRM];
      xfer.is_read   = (wdata == CMD_READ);
      xfer.internal  = param_q[P_INTSEL];
      xfer.seg       = param_q[P_BUS_LSB +: 3];
      xfer.phy       = param_q[P_PHY_LSB +: 5];
      xfer.raddr     = raddr_q;
      xfer.wdata     = param_q[15:0];
   end

   always_comb begin
      unique case (addr)
         OFS_PARAM: rdata = param_q;
         OFS_RDATA: rdata = {16'h0, cap_data};
         OFS_ADDR:  rdata = raddr_q;
         OFS_STAT:  rdata = {31'h0, done_q};
         default:   rdata = '0;
      endcase
   end

   // R11: a completion never lands on an already-set done flag
   a_r11_done_once: assert property (@(posedge clk) disable iff (!rst_n)
      done_set |-> !done_q);
   // R3: done only falls after a zero written to the control word
   a_r3_clear_by_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_q) |-> ($past(we) && $past(addr) == OFS_CTRL && $past(wdata) == '0));

endmodule

// File: rtl/mdio_mux_engine.sv
module mdio_mux_engine
   import mdio_mux_pkg::*;
#(
   parameter int MDC_HALF = 10
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  xfer_t       xfer,
   input  logic        mdi,
   output logic        busy,
   output logic        mdc,
   output logic        mdo,
   output logic        moe,
   output logic        done_set,
   output logic [15:0] rdata
);

   localparam int PERIOD = 2 * MDC_HALF;
   localparam int CNT_W  = $clog2(PERIOD);
   localparam logic [CNT_W-1:0] CNT_RISE = CNT_W'(MDC_HALF - 1);
   localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(PERIOD - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [6:0]       pos_q;
   logic             busy_q, mdc_q;
   xfer_t            x_q;
   logic [15:0]      rd_q;

   logic        in_pre, op_frame, at_rise, at_end, capture, release_bus;
   logic [4:0]  fpos;
   logic [6:0]  last_pos;
   logic [31:0] word;

   assign in_pre   = ~pos_q[5];
   assign fpos     = pos_q[4:0];
   assign op_frame = ~x_q.ext_frame | pos_q[6];
   assign last_pos = x_q.ext_frame ? 7'd127 : 7'd63;
   assign at_rise  = busy_q && (cnt_q == CNT_RISE);
   assign at_end   = busy_q && (cnt_q == CNT_END);
   assign done_set = at_end && (pos_q == last_pos);
   assign capture  = at_rise && x_q.is_read && op_frame && !in_pre && (fpos >= 5'd16);
   assign release_bus = x_q.is_read && op_frame && !in_pre && (fpos >= 5'd14);

   always_comb begin
      if (x_q.ext_frame && !pos_q[6])
         word = mk_frame(2'b00, 2'b00, x_q.phy, x_q.raddr[20:16], x_q.raddr[15:0]);
      else if (x_q.ext_frame)
         word = mk_frame(2'b00, x_q.is_read ? 2'b11 : 2'b01, x_q.phy,
                         x_q.raddr[20:16], x_q.wdata);
      else
         word = mk_frame(2'b01, x_q.is_read ? 2'b10 : 2'b01, x_q.phy,
                         x_q.raddr[4:0], x_q.wdata);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         mdc_q  <= 1'b0;
         cnt_q  <= '0;
         pos_q  <= '0;
         x_q    <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         mdc_q  <= 1'b0;
         cnt_q  <= '0;
         pos_q  <= '0;
         x_q    <= xfer;
      end else if (busy_q) begin
         if (at_end) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
            if (done_set) busy_q <= 1'b0;
            else          pos_q  <= pos_q + 7'd1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            if (at_rise) mdc_q <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_q <= '0;
      else if (capture) rd_q <= {rd_q[14:0], mdi};
   end

   assign busy  = busy_q;
   assign mdc   = mdc_q;
   assign mdo   = in_pre ? 1'b1 : word[5'd31 - fpos];
   assign moe   = busy_q && !release_bus;
   assign rdata = rd_q;

   // R5: MDC idles low
   a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !mdc_q);
   // R5: MDC rises only after MDC_HALF low clocks of a bit
   a_r5_rise_point: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $rose(mdc_q)) |-> (cnt_q == CNT_W'(MDC_HALF)));
   // R5: data out holds while MDC stays high
   a_r5_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q) && mdc_q && $past(mdc_q)) |-> $stable(mdo));
   // R8: the bus is never driven while idle
   a_r8_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !moe);
   // R4: a start reaches the engine only when it is idle
   a_r4_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy_q);

endmodule

// File: rtl/mdio_mux_steer.sv
module mdio_mux_steer
   import mdio_mux_pkg::*;
#(
   parameter int N_INT = 4,
   parameter int N_EXT = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             sel_internal,
   input  logic [2:0]       sel_seg,
   input  logic             mdc,
   input  logic             mdo,
   input  logic             moe,
   output logic             mdi,
   output logic [N_INT-1:0] int_mdc,
   output logic [N_INT-1:0] int_mdio_o,
   output logic [N_INT-1:0] int_mdio_oe,
   input  logic [N_INT-1:0] int_mdio_i,
   output logic [N_EXT-1:0] ext_mdc,
   output logic [N_EXT-1:0] ext_mdio_o,
   output logic [N_EXT-1:0] ext_mdio_oe,
   input  logic [N_EXT-1:0] ext_mdio_i
);

   logic             internal_q;
   logic [2:0]       seg_q;
   logic [N_INT-1:0] int_hit;
   logic [N_EXT-1:0] ext_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         internal_q <= 1'b0;
         seg_q      <= '0;
      end else if (start) begin
         internal_q <= sel_internal;
         seg_q      <= sel_seg;
      end
   end

   for (genvar i = 0; i < N_INT; i++) begin : g_int
      assign int_hit[i]     = internal_q && (seg_q == 3'(i));
      assign int_mdc[i]     = int_hit[i] & mdc;
      assign int_mdio_oe[i] = int_hit[i] & moe;
      assign int_mdio_o[i]  = int_hit[i] & moe & mdo;
   end

   for (genvar j = 0; j < N_EXT; j++) begin : g_ext
      assign ext_hit[j]     = !internal_q && (seg_q == 3'(j));
      assign ext_mdc[j]     = ext_hit[j] & mdc;
      assign ext_mdio_oe[j] = ext_hit[j] & moe;
      assign ext_mdio_o[j]  = ext_hit[j] & moe & mdo;
   end

   // an unimplemented segment reads as an idle, pulled-up line
   assign mdi = (|(int_hit & int_mdio_i)) | (|(ext_hit & ext_mdio_i)) |
                ~(|{int_hit, ext_hit});

   // R9: at most one segment sees a clock
   a_r9_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ext_mdc, int_mdc}));
   // R10: the selection is frozen while a frame is on the wire
   a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> ($stable(seg_q) && $stable(internal_q)));

endmodule

// File: rtl/mdio_mux_master.sv
module mdio_mux_master
   import mdio_mux_pkg::*;
#(
   parameter int N_INT    = 4,
   parameter int N_EXT    = 4,
   parameter int MDC_HALF = 10
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [4:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   output logic [N_INT-1:0] int_mdc,
   output logic [N_INT-1:0] int_mdio_o,
   output logic [N_INT-1:0] int_mdio_oe,
   input  logic [N_INT-1:0] int_mdio_i,
   output logic [N_EXT-1:0] ext_mdc,
   output logic [N_EXT-1:0] ext_mdio_o,
   output logic [N_EXT-1:0] ext_mdio_oe,
   input  logic [N_EXT-1:0] ext_mdio_i
);

   initial begin
      a_cfg_int: assert (N_INT >= 1 && N_INT <= 8) else $error("N_INT must be 1..8");
      a_cfg_ext: assert (N_EXT >= 1 && N_EXT <= 8) else $error("N_EXT must be 1..8");
      a_cfg_div: assert (MDC_HALF >= 1) else $error("MDC_HALF must be at least 1");
   end

   logic        start, busy, done_set, mdc, mdo, moe, mdi;
   logic [15:0] cap_data;
   xfer_t       xfer;

   mdio_mux_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .busy     (busy),
      .done_set (done_set),
      .cap_data (cap_data),
      .rdata    (reg_rdata),
      .start    (start),
      .xfer     (xfer)
   );

   mdio_mux_engine #(.MDC_HALF(MDC_HALF)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .xfer     (xfer),
      .mdi      (mdi),
      .busy     (busy),
      .mdc      (mdc),
      .mdo      (mdo),
      .moe      (moe),
      .done_set (done_set),
      .rdata    (cap_data)
   );

   mdio_mux_steer #(.N_INT(N_INT), .N_EXT(N_EXT)) u_steer (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .sel_internal (xfer.internal),
      .sel_seg      (xfer.seg),
      .mdc          (mdc),
      .mdo          (mdo),
      .moe          (moe),
      .mdi          (mdi),
      .int_mdc      (int_mdc),
      .int_mdio_o   (int_mdio_o),
      .int_mdio_oe  (int_mdio_oe),
      .int_mdio_i   (int_mdio_i),
      .ext_mdc      (ext_mdc),
      .ext_mdio_o   (ext_mdio_o),
      .ext_mdio_oe  (ext_mdio_oe),
      .ext_mdio_i   (ext_mdio_i)
   );

endmodule

// File: tb/test_mdio_mux_master.sv
`timescale 1ns/1ps
module test_mdio_mux_master;

   localparam int HALF = 2;
   localparam int NI   = 3;
   localparam int NE   = 2;
   localparam int PER  = 2 * HALF;

   localparam logic [4:0] A_PARAM = 5'h00;
   localparam logic [4:0] A_RDATA = 5'h04;
   localparam logic [4:0] A_ADDR  = 5'h08;
   localparam logic [4:0] A_CTRL  = 5'h0C;
   localparam logic [4:0] A_STAT  = 5'h10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [4:0]    reg_addr = A_STAT;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [NI-1:0] int_mdc, int_mdio_o, int_mdio_oe;
   logic [NI-1:0] int_mdio_i = '1;
   logic [NE-1:0] ext_mdc, ext_mdio_o, ext_mdio_oe;
   logic [NE-1:0] ext_mdio_i = '1;

   always #2.5 clk = ~clk;

   mdio_mux_master #(.N_INT(NI), .N_EXT(NE), .MDC_HALF(HALF)) i_mdio_mux_master (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .int_mdc(int_mdc), .int_mdio_o(int_mdio_o), .int_mdio_oe(int_mdio_oe),
      .int_mdio_i(int_mdio_i),
      .ext_mdc(ext_mdc), .ext_mdio_o(ext_mdio_o), .ext_mdio_oe(ext_mdio_oe),
      .ext_mdio_i(ext_mdio_i)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   int    cyc = 0;
   string cur_tag = "R1 reset pins";

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   bit          mq_val[$];
   bit          mq_drv[$];
   int          mq_cap[$];
   int          k;
   bit          m_busy, m_done, m_rd, m_int, m_hit;
   int          m_seg;
   logic [31:0] m_param, m_addr;
   logic [15:0] m_rdata;
   logic [15:0] phy_val = 16'h0000;

   task automatic push_frame(input logic [31:0] w, input bit rd_frame);
      for (int i = 0; i < 32; i++) begin
         mq_val.push_back(1'b1); mq_drv.push_back(1'b1); mq_cap.push_back(-1);
      end
      for (int i = 0; i < 32; i++) begin
         mq_val.push_back(w[31-i]);
         mq_drv.push_back(!(rd_frame && i >= 14));
         mq_cap.push_back((rd_frame && i >= 16) ? 31 - i : -1);
      end
   endtask

   task automatic model_start(input bit rd);
      logic [4:0]  phy;
      logic [15:0] dat;
      mq_val.delete(); mq_drv.delete(); mq_cap.delete();
      phy   = m_param[20:16];
      dat   = m_param[15:0];
      m_rd  = rd;
      m_int = m_param[25];
      m_seg = int'(m_param[24:22]);
      m_hit = m_int ? (m_seg < NI) : (m_seg < NE);
      if (m_param[21]) begin
         push_frame({2'b00, 2'b00, phy, m_addr[20:16], 2'b10, m_addr[15:0]}, 1'b0);
         push_frame({2'b00, rd ? 2'b11 : 2'b01, phy, m_addr[20:16], 2'b10, dat}, rd);
      end else begin
         push_frame({2'b01, rd ? 2'b10 : 2'b01, phy, m_addr[4:0], 2'b10, dat}, rd);
      end
      m_busy = 1'b1;
      k = 0;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_param = '0; m_addr = '0; m_rdata = '0; k = 0;
      end else begin
         if (m_busy) begin
            k++;
            if (k == mq_val.size() * PER) begin
               m_busy = 0;
               m_done = 1;
               if (m_rd) m_rdata = m_hit ? phy_val : 16'hFFFF;
            end
         end else if (reg_we && reg_addr == A_CTRL) begin
            if (!m_done && (reg_wdata == 32'h1 || reg_wdata == 32'h2))
               model_start(reg_wdata == 32'h2);
            else if (reg_wdata == 32'h0)
               m_done = 0;
         end
         if (reg_we && reg_addr == A_PARAM) m_param = reg_wdata;
         if (reg_we && reg_addr == A_ADDR)  m_addr  = reg_wdata;
      end
   end

   // per-cycle comparison and PHY responder
   always @(negedge clk) begin
      logic [NI-1:0] e_imdc, e_io, e_ioe, phy_i;
      logic [NE-1:0] e_emdc, e_eo, e_eoe, phy_e;
      e_imdc = '0; e_io = '0; e_ioe = '0; phy_i = '1;
      e_emdc = '0; e_eo = '0; e_eoe = '0; phy_e = '1;
      cyc++;
      if (rst_n && m_busy && m_hit) begin
         int  b;
         bit  ph;
         b  = k / PER;
         ph = (k % PER) >= HALF;
         if (m_int) begin
            e_imdc[m_seg] = ph;
            e_ioe[m_seg]  = mq_drv[b];
            e_io[m_seg]   = mq_drv[b] & mq_val[b];
            if (mq_cap[b] >= 0) phy_i[m_seg] = phy_val[mq_cap[b]];
         end else begin
            e_emdc[m_seg] = ph;
            e_eoe[m_seg]  = mq_drv[b];
            e_eo[m_seg]   = mq_drv[b] & mq_val[b];
            if (mq_cap[b] >= 0) phy_e[m_seg] = phy_val[mq_cap[b]];
         end
      end
      chk(cur_tag, 64'({int_mdc, int_mdio_o, int_mdio_oe, ext_mdc, ext_mdio_o, ext_mdio_oe}),
          64'({e_imdc, e_io, e_ioe, e_emdc, e_eo, e_eoe}));
      if (rst_n && reg_addr == A_STAT)
         chk({cur_tag, " R11 done"}, 64'(reg_rdata), 64'(m_done));
      int_mdio_i <= phy_i;
      ext_mdio_i <= phy_e;
   end

   // ---------------- stimulus ----------------
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); #1;
      reg_we = 1'b0; reg_addr = A_STAT;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] v);
      @(negedge clk); #1;
      reg_addr = a;
      #1 v = reg_rdata;
      @(negedge clk); #1;
      reg_addr = A_STAT;
   endtask

   task automatic wait_done();
      int n = 0;
      while (!m_done && n < 2000) begin
         @(negedge clk); n++;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic run(input logic [31:0] p, input logic [31:0] a, input logic [31:0] op);
      wr(A_PARAM, p);
      wr(A_ADDR, a);
      wr(A_CTRL, op);
      wait_done();
   endtask

   always @(posedge clk) begin
      if (cyc > 100000) begin
         n_fail++;
         $display("FAIL watchdog R11 actual=hung expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(A_PARAM, v); chk("R1 param reset", 64'(v), 64'h0);
      rd(A_ADDR, v);  chk("R1 addr reset", 64'(v), 64'h0);
      rd(A_STAT, v);  chk("R1 status reset", 64'(v), 64'h0);

      cur_tag = "R2 readback";
      wr(A_PARAM, 32'hDEAD_BEEF); rd(A_PARAM, v); chk("R2 param rw", 64'(v), 64'hDEADBEEF);
      wr(A_ADDR, 32'h0013_5A5A);  rd(A_ADDR, v);  chk("R2 addr rw", 64'(v), 64'h00135A5A);
      rd(A_CTRL, v);  chk("R2 ctrl reads zero", 64'(v), 64'h0);
      rd(5'h14, v);   chk("R2 unmapped reads zero", 64'(v), 64'h0);

      // basic write, internal segment 1
      cur_tag = "R6 R5 R9 basic write internal";
      run({6'b0, 1'b1, 3'd1, 1'b0, 5'd5, 16'hA5C3}, 32'h3, 32'h1);
      rd(A_STAT, v); chk("R11 done after write", 64'(v), 64'h1);
      rd(A_RDATA, v); chk("R8 write keeps read data", 64'(v), 64'h0);

      cur_tag = "R3 clear";
      wr(A_CTRL, 32'h0);
      rd(A_STAT, v); chk("R3 zero clears done", 64'(v), 64'h0);

      // basic read, external segment 0
      cur_tag = "R6 R8 basic read external";
      phy_val = 16'hBEEF;
      run({6'b0, 1'b0, 3'd0, 1'b0, 5'h1F, 16'h0}, 32'h1A, 32'h2);
      rd(A_RDATA, v); chk("R8 read data basic", 64'(v), 64'hBEEF);
      wr(A_CTRL, 32'h0);

      // extended write, internal segment 2
      cur_tag = "R7 extended write";
      run({6'b0, 1'b1, 3'd2, 1'b1, 5'd9, 16'h5678}, {11'b0, 5'd7, 16'h1234}, 32'h1);
      rd(A_STAT, v); chk("R7 done after extended write", 64'(v), 64'h1);
      rd(A_RDATA, v); chk("R8 read data kept after write", 64'(v), 64'hBEEF);
      wr(A_CTRL, 32'h0);

      // extended read on external segment 1, with register traffic mid-access
      cur_tag = "R7 R10 R4 extended read";
      phy_val = 16'h1357;
      wr(A_PARAM, {6'b0, 1'b0, 3'd1, 1'b1, 5'd3, 16'h0});
      wr(A_ADDR, {11'b0, 5'd1, 16'hC0DE});
      wr(A_CTRL, 32'h2);
      repeat (40) @(negedge clk);
      wr(A_PARAM, {6'b0, 1'b1, 3'd0, 1'b0, 5'd1, 16'hFFFF});
      wr(A_ADDR, 32'h0);
      wr(A_CTRL, 32'h1);
      wr(A_CTRL, 32'h0);
      wait_done();
      rd(A_RDATA, v); chk("R10 R7 read data extended", 64'(v), 64'h1357);
      rd(A_STAT, v); chk("R4 busy writes ignored, done set", 64'(v), 64'h1);

      cur_tag = "R4 start while done";
      wr(A_CTRL, 32'h1);
      repeat (20) @(negedge clk);
      rd(A_STAT, v); chk("R4 start with done set ignored", 64'(v), 64'h1);

      cur_tag = "R3 invalid command";
      wr(A_CTRL, 32'h0);
      wr(A_CTRL, 32'h3);
      repeat (20) @(negedge clk);
      rd(A_STAT, v); chk("R3 command 3 starts nothing", 64'(v), 64'h0);

      cur_tag = "R9 unimplemented segment";
      phy_val = 16'h0F0F;
      run({6'b0, 1'b1, 3'd5, 1'b0, 5'd2, 16'h0}, 32'h4, 32'h2);
      rd(A_STAT, v); chk("R9 unimplemented completes", 64'(v), 64'h1);
      rd(A_RDATA, v); chk("R9 unimplemented reads ones", 64'(v), 64'hFFFF);

      repeat (4) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule